// File: doc/BRIEF.md
# Superscalar Issue Group Former

This block sits at the head of an in-order instruction buffer and decides, each cycle, how many of the up to four decoded instructions waiting there may leave together as one issue group. Every slot presents a valid flag, a two-bit category, two address/operand source registers, a store-data register with a store flag, and a destination register with a write enable. From these the block forms the longest in-order prefix that breaks none of the grouping rules. It then presents that prefix as a dispatch mask and a count.

The group is cut where a later slot reads a register written earlier in the group, or writes a register already written earlier in the group. It is never cut when a later slot overwrites a register that an earlier slot only reads. A store may take its data from an integer ALU result produced earlier in the same group. Category rules also apply: a serialising instruction issues alone, and a group holds at most one memory access and at most one control transfer. A downstream stall holds the group at zero. The mask and count are registered, so they show the decision on the inputs sampled at the previous clock edge.

Top module: `grp_issue_check`

## Requirements
- R1: While reset is asserted and on the first edge after it, `grpCount` is 0 and `grpMask` is 0.
- R2: The outputs follow the inputs one clock later. `grpMask` is a contiguous run of ones starting at bit 0 (slot 0). `grpCount` equals the number of ones in it, which is at most 4.
- R3: A slot whose `srcA` or `srcB` equals the nonzero destination of an earlier write-enabled slot in the group is excluded, and so are all slots after it.
- R4: A write-enabled slot whose nonzero destination equals the destination of an earlier write-enabled slot in the group is excluded, together with all later slots.
- R5: A slot that writes a register read by an earlier slot in the group is not excluded for that reason.
- R6: A store (store flag set, category 3) whose data register is written by an earlier slot of category 1 (integer ALU) stays in the group. If that writer has any other category, the store is excluded. The store's `srcA`/`srcB` still obey R3.
- R7: Category 0 (serialising) issues alone. In slot 0 it yields mask 0001. In any later slot, the group ends just before it.
- R8: A group holds at most one slot of category 3 (load/store) and at most one of category 2 (control transfer). A second one ends the group before it.
- R9: Register number 0 never creates a dependency, whether it is written or read.
- R10: When `stall` was high at the sampling edge, the next `grpCount` and `grpMask` are 0.
- R11: A slot whose valid bit is 0 ends the group. Valid slots after it are not dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Downstream stall; forces an empty group |
| slotValid | input | 4 | Valid flag per slot, bit i = slot i |
| slotCat | input | 8 | Category per slot, bits [2i+1:2i]: 0 serialising, 1 ALU, 2 control, 3 load/store |
| slotSrcA | input | 20 | First source register per slot, bits [5i+4:5i] |
| slotSrcB | input | 20 | Second source register per slot, bits [5i+4:5i] |
| slotStData | input | 20 | Store data register per slot, used only when the store flag is set |
| slotIsStore | input | 4 | Store flag per slot |
| slotDst | input | 20 | Destination register per slot |
| slotWrEn | input | 4 | Destination write enable per slot |
| grpCount | output | 3 | Number of slots in the issued group (0..4) |
| grpMask | output | 4 | Dispatch mask, bit i = slot i issued |

## Verification
The assertions assume that `stall`, `slotValid` and `slotCat` are known, driven values at every clock edge after reset. They also assume that a slot's category and store flag agree: a store flag is only set on a category-3 slot. The bench drives every input between falling and rising edges. It clears unused slots to invalid with register 0 in every field, and only sets the store flag on load/store slots. Each directed scenario holds its inputs stable for a full cycle before the registered result is read.

// File: rtl/grp_pkg.sv
package grp_pkg;

  typedef enum logic [1:0] {
    CAT_SOLO = 2'd0,
    CAT_ALU  = 2'd1,
    CAT_CTRL = 2'd2,
    CAT_MEM  = 2'd3
  } grpCat_e;

  // strobes passed from the category control to the hazard datapath
  typedef struct packed {
    logic holdIssue;  // downstream stall: register an empty group
    logic soloHead;   // slot 0 is serialising: group is slot 0 only
  } grpStrobe_t;

endpackage

// File: rtl/grp_cat_ctrl.sv
module grp_cat_ctrl
  import grp_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           stall,
  input  logic [N-1:0]   slotValid,
  input  logic [2*N-1:0] slotCat,
  output logic [N-1:0]   catOk,
  output grpStrobe_t     strobe
);

  // per-slot category flags
  logic [N-1:0] isMem, isCtrl, isSolo;

  for (genvar g = 0; g < N; g++) begin : g_decode
    assign isMem[g]  = grpCat_e'(slotCat[2*g +: 2]) == CAT_MEM;
    assign isCtrl[g] = grpCat_e'(slotCat[2*g +: 2]) == CAT_CTRL;
    assign isSolo[g] = grpCat_e'(slotCat[2*g +: 2]) == CAT_SOLO;
  end

  // a slot may join when valid, not a late serialiser, and no earlier slot
  // already used the memory or control-transfer resource
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic memSeen;
      logic ctrlSeen;
      memSeen  = 1'b0;
      ctrlSeen = 1'b0;
      for (int j = 0; j < i; j++) begin
        memSeen  = memSeen  | isMem[j];
        ctrlSeen = ctrlSeen | isCtrl[j];
      end
      catOk[i] = slotValid[i]
               & ~(isSolo[i] & (i != 0))
               & ~(isMem[i]  & memSeen)
               & ~(isCtrl[i] & ctrlSeen);
    end
  end

  assign strobe.holdIssue = stall;
  assign strobe.soloHead  = slotValid[0] & isSolo[0];

endmodule

// File: rtl/grp_hazard_dp.sv
module grp_hazard_dp
  import grp_pkg::*;
#(
  parameter int N  = 4,
  parameter int RW = 5,
  localparam int CW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*N-1:0]  slotCat,
  input  logic [N*RW-1:0] slotSrcA,
  input  logic [N*RW-1:0] slotSrcB,
  input  logic [N*RW-1:0] slotStData,
  input  logic [N-1:0]    slotIsStore,
  input  logic [N*RW-1:0] slotDst,
  input  logic [N-1:0]    slotWrEn,
  input  logic [N-1:0]    catOk,
  input  grpStrobe_t      strobe,
  output logic [CW-1:0]   grpCount,
  output logic [N-1:0]    grpMask
);

  logic [N-1:0]  regHaz;
  logic [N-1:0]  nextMask;
  logic [CW-1:0] nextCount;

  // register hazards of slot i against every earlier slot j
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic hit;
      hit = 1'b0;
      for (int j = 0; j < i; j++) begin
        logic          wrLive;
        logic [RW-1:0] dstJ;
        dstJ   = slotDst[j*RW +: RW];
        wrLive = slotWrEn[j] & (dstJ != '0);
        // read after write on address/operand sources
        if (wrLive && (dstJ == slotSrcA[i*RW +: RW] || dstJ == slotSrcB[i*RW +: RW]))
          hit = 1'b1;
        // store data only forwards from an ALU result
        if (wrLive && slotIsStore[i] && dstJ == slotStData[i*RW +: RW] &&
            grpCat_e'(slotCat[2*j +: 2]) != CAT_ALU)
          hit = 1'b1;
        // write after write
        if (wrLive && slotWrEn[i] && dstJ == slotDst[i*RW +: RW])
          hit = 1'b1;
      end
      regHaz[i] = hit;
    end
  end

  // in-order prefix of acceptable slots
  always_comb begin
    logic run;
    run       = 1'b1;
    nextCount = '0;
    for (int i = 0; i < N; i++) begin
      run = run & catOk[i] & ~regHaz[i] & ~(strobe.soloHead & (i != 0));
      nextMask[i] = run;
      nextCount   = nextCount + CW'(run);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.holdIssue) begin
      grpMask  <= '0;
      grpCount <= '0;
    end else begin
      grpMask  <= nextMask;
      grpCount <= nextCount;
    end
  end

endmodule

// File: rtl/grp_issue_check.sv
module grp_issue_check
  import grp_pkg::*;
#(
  parameter int N  = 4,
  parameter int RW = 5,
  localparam int CW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [N-1:0]    slotValid,
  input  logic [2*N-1:0]  slotCat,
  input  logic [N*RW-1:0] slotSrcA,
  input  logic [N*RW-1:0] slotSrcB,
  input  logic [N*RW-1:0] slotStData,
  input  logic [N-1:0]    slotIsStore,
  input  logic [N*RW-1:0] slotDst,
  input  logic [N-1:0]    slotWrEn,
  output logic [CW-1:0]   grpCount,
  output logic [N-1:0]    grpMask
);

  logic [N-1:0] catOk;
  grpStrobe_t   strobe;

  grp_cat_ctrl #(.N(N)) u_ctrl (
    .stall     (stall),
    .slotValid (slotValid),
    .slotCat   (slotCat),
    .catOk     (catOk),
    .strobe    (strobe)
  );

  grp_hazard_dp #(.N(N), .RW(RW)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .slotCat     (slotCat),
    .slotSrcA    (slotSrcA),
    .slotSrcB    (slotSrcB),
    .slotStData  (slotStData),
    .slotIsStore (slotIsStore),
    .slotDst     (slotDst),
    .slotWrEn    (slotWrEn),
    .catOk       (catOk),
    .strobe      (strobe),
    .grpCount    (grpCount),
    .grpMask     (grpMask)
  );

endmodule

// File: rtl/grp_issue_check_sva.sv
module grp_issue_check_sva
  import grp_pkg::*;
#(
  parameter int N  = 4,
  localparam int CW = $clog2(N + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           stall,
  input logic [N-1:0]   slotValid,
  input logic [2*N-1:0] slotCat,
  input logic [CW-1:0]  grpCount,
  input logic [N-1:0]   grpMask
);

  logic         pastOk;
  logic         prevStall;
  logic [N-1:0] prevValid;
  logic [N-1:0] prevMem;
  logic [N-1:0] prevCtrl;
  logic         prevSolo0;
  logic [N:0]   maskPlusOne;

  always_ff @(posedge clk) begin
    if (rst) begin
      pastOk    <= 1'b0;
      prevStall <= 1'b0;
      prevValid <= '0;
      prevMem   <= '0;
      prevCtrl  <= '0;
      prevSolo0 <= 1'b0;
    end else begin
      pastOk    <= 1'b1;
      prevStall <= stall;
      prevValid <= slotValid;
      prevSolo0 <= slotValid[0] && slotCat[1:0] == CAT_SOLO;
      for (int i = 0; i < N; i++) begin
        prevMem[i]  <= slotCat[2*i +: 2] == CAT_MEM;
        prevCtrl[i] <= slotCat[2*i +: 2] == CAT_CTRL;
      end
    end
  end

  assign maskPlusOne = {1'b0, grpMask} + 1'b1;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (grpCount == '0 && grpMask == '0));

  // R2
  a_r2_prefix_mask: assert property (@(posedge clk) disable iff (rst)
    (maskPlusOne[N-1:0] & grpMask) == '0);

  // R2
  a_r2_count_match: assert property (@(posedge clk) disable iff (rst)
    $countones(grpMask) == int'(grpCount));

  // R10
  a_r10_stall_empty: assert property (@(posedge clk) disable iff (rst)
    (pastOk && prevStall) |-> (grpCount == '0));

  // R11
  a_r11_valid_only: assert property (@(posedge clk) disable iff (rst)
    pastOk |-> ((grpMask & ~prevValid) == '0));

  // R7
  a_r7_solo_head: assert property (@(posedge clk) disable iff (rst)
    (pastOk && !prevStall && prevSolo0) |-> (grpMask == N'(1)));

  // R8
  a_r8_one_mem: assert property (@(posedge clk) disable iff (rst)
    $countones(grpMask & prevMem) <= 1);

  // R8
  a_r8_one_ctrl: assert property (@(posedge clk) disable iff (rst)
    $countones(grpMask & prevCtrl) <= 1);

endmodule

bind grp_issue_check grp_issue_check_sva #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .slotValid (slotValid),
  .slotCat   (slotCat),
  .grpCount  (grpCount),
  .grpMask   (grpMask)
);

// File: tb/grp_issue_check_tb.sv
module grp_issue_check_tb;

  localparam int N  = 4;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;

  logic [N-1:0]    slotValid;
  logic [2*N-1:0]  slotCat;
  logic [N*RW-1:0] slotSrcA, slotSrcB, slotStData, slotDst;
  logic [N-1:0]    slotIsStore, slotWrEn;
  logic [2:0]      grpCount;
  logic [N-1:0]    grpMask;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  grp_issue_check #(.N(N), .RW(RW)) u_dut (
    .clk(clk), .rst(rst), .stall(stall),
    .slotValid(slotValid), .slotCat(slotCat),
    .slotSrcA(slotSrcA), .slotSrcB(slotSrcB), .slotStData(slotStData),
    .slotIsStore(slotIsStore), .slotDst(slotDst), .slotWrEn(slotWrEn),
    .grpCount(grpCount), .grpMask(grpMask)
  );

  task automatic clear_slots();
    slotValid = '0; slotCat = '0; slotSrcA = '0; slotSrcB = '0;
    slotStData = '0; slotIsStore = '0; slotDst = '0; slotWrEn = '0;
  endtask

  // cat: 0 serialising, 1 ALU, 2 control, 3 load/store
  task automatic set_slot(input int s, input logic [1:0] cat,
                          input logic [4:0] a, input logic [4:0] b,
                          input logic [4:0] sd, input logic st,
                          input logic [4:0] d, input logic we);
    slotValid[s]        = 1'b1;
    slotCat[2*s +: 2]   = cat;
    slotSrcA[RW*s +: RW]   = a;
    slotSrcB[RW*s +: RW]   = b;
    slotStData[RW*s +: RW] = sd;
    slotIsStore[s]      = st;
    slotDst[RW*s +: RW] = d;
    slotWrEn[s]         = we;
  endtask

  // inputs already set; one rising edge registers the result
  task automatic expect_group(input string req, input int expCount, input logic [3:0] expMask);
    @(negedge clk);
    checks++;
    if (int'(grpCount) != expCount || grpMask != expMask) begin
      errors++;
      $display("FAIL %s: count=%0d mask=%b expected count=%0d mask=%b",
               req, grpCount, grpMask, expCount, expMask);
    end
  endtask

  task automatic t_reset();
    clear_slots();
    set_slot(0, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd3, 1'b1);
    repeat (2) @(negedge clk);
    checks++;
    if (grpCount != 0 || grpMask != 0) begin
      errors++;
      $display("FAIL R1: count=%0d mask=%b expected count=0 mask=0000", grpCount, grpMask);
    end
    rst = 1'b0;
  endtask

  task automatic t_independent();
    clear_slots();
    for (int s = 0; s < 4; s++)
      set_slot(s, 2'd1, 5'(s + 1), 5'(s + 10), 5'd0, 1'b0, 5'(s + 20), 1'b1);
    expect_group("R2", 4, 4'b1111);
  endtask

  task automatic t_invalid_gap();
    clear_slots();
    set_slot(0, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd10, 1'b1);
    set_slot(1, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd11, 1'b1);
    set_slot(3, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd12, 1'b1);
    expect_group("R11", 2, 4'b0011);
  endtask

  task automatic t_raw();
    clear_slots();
    set_slot(0, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd5, 1'b1);
    set_slot(1, 2'd1, 5'd5, 5'd2, 5'd0, 1'b0, 5'd6, 1'b1);
    set_slot(2, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd7, 1'b1);
    expect_group("R3 srcA", 1, 4'b0001);
    clear_slots();
    set_slot(0, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd5, 1'b1);
    set_slot(1, 2'd1, 5'd3, 5'd4, 5'd0, 1'b0, 5'd6, 1'b1);
    set_slot(2, 2'd1, 5'd8, 5'd6, 5'd0, 1'b0, 5'd7, 1'b1);
    set_slot(3, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd9, 1'b1);
    expect_group("R3 srcB", 2, 4'b0011);
  endtask

  task automatic t_waw();
    clear_slots();
    set_slot(0, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd7, 1'b1);
    set_slot(1, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd3, 1'b1);
    set_slot(2, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd7, 1'b1);
    set_slot(3, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd8, 1'b1);
    expect_group("R4", 2, 4'b0011);
  endtask

  task automatic t_war();
    clear_slots();
    set_slot(0, 2'd1, 5'd9, 5'd2, 5'd0, 1'b0, 5'd4, 1'b1);
    set_slot(1, 2'd1, 5'd1, 5'd3, 5'd0, 1'b0, 5'd9, 1'b1);
    set_slot(2, 2'd1, 5'd1, 5'd6, 5'd0, 1'b0, 5'd2, 1'b1);
    set_slot(3, 2'd1, 5'd6, 5'd1, 5'd0, 1'b0, 5'd3, 1'b1);
    expect_group("R5", 4, 4'b1111);
  endtask

  task automatic t_store_data();
    clear_slots();
    set_slot(0, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd4, 1'b1);
    set_slot(1, 2'd3, 5'd8, 5'd0, 5'd4, 1'b1, 5'd0, 1'b0);
    set_slot(2, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd12, 1'b1);
    set_slot(3, 2'd2, 5'd3, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
    expect_group("R6 alu forward", 4, 4'b1111);
    clear_slots();
    set_slot(0, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd4, 1'b1);
    set_slot(1, 2'd3, 5'd4, 5'd0, 5'd9, 1'b1, 5'd0, 1'b0);
    expect_group("R6 address", 1, 4'b0001);
    clear_slots();
    set_slot(0, 2'd2, 5'd1, 5'd0, 5'd0, 1'b0, 5'd6, 1'b1);
    set_slot(1, 2'd3, 5'd8, 5'd0, 5'd6, 1'b1, 5'd0, 1'b0);
    expect_group("R6 non-alu", 1, 4'b0001);
  endtask

  task automatic t_solo();
    clear_slots();
    set_slot(0, 2'd0, 5'd1, 5'd2, 5'd0, 1'b0, 5'd3, 1'b1);
    set_slot(1, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd4, 1'b1);
    expect_group("R7 head", 1, 4'b0001);
    clear_slots();
    set_slot(0, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd3, 1'b1);
    set_slot(1, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd4, 1'b1);
    set_slot(2, 2'd0, 5'd1, 5'd2, 5'd0, 1'b0, 5'd5, 1'b1);
    set_slot(3, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd6, 1'b1);
    expect_group("R7 later", 2, 4'b0011);
  endtask

  task automatic t_resources();
    clear_slots();
    set_slot(0, 2'd3, 5'd1, 5'd0, 5'd0, 1'b0, 5'd10, 1'b1);
    set_slot(1, 2'd1, 5'd2, 5'd3, 5'd0, 1'b0, 5'd11, 1'b1);
    set_slot(2, 2'd3, 5'd2, 5'd0, 5'd0, 1'b0, 5'd12, 1'b1);
    expect_group("R8 mem", 2, 4'b0011);
    clear_slots();
    set_slot(0, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd10, 1'b1);
    set_slot(1, 2'd2, 5'd3, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
    set_slot(2, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd11, 1'b1);
    set_slot(3, 2'd2, 5'd4, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
    expect_group("R8 ctrl", 3, 4'b0111);
  endtask

  task automatic t_zero_reg();
    clear_slots();
    set_slot(0, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd0, 1'b1);
    set_slot(1, 2'd1, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1);
    set_slot(2, 2'd2, 5'd0, 5'd1, 5'd0, 1'b0, 5'd0, 1'b1);
    set_slot(3, 2'd3, 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b0);
    expect_group("R9", 4, 4'b1111);
  endtask

  task automatic t_stall();
    clear_slots();
    for (int s = 0; s < 4; s++)
      set_slot(s, 2'd1, 5'd1, 5'd2, 5'd0, 1'b0, 5'(s + 20), 1'b1);
    stall = 1'b1;
    expect_group("R10 stalled", 0, 4'b0000);
    stall = 1'b0;
    expect_group("R10 released", 4, 4'b1111);
  endtask

  initial begin
    t_reset();
    t_independent();
    t_invalid_gap();
    t_raw();
    t_waw();
    t_war();
    t_store_data();
    t_solo();
    t_resources();
    t_zero_reg();
    t_stall();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule